// File: doc/BRIEF.md
# Edge-Triggered Lockout Deglitcher

This block cleans up a repeating digital signal whose every transition is followed by a short burst of ringing. It reacts to the first edge of each burst, whether rising or falling. The clean output then takes the new level on the next clock after the edge is seen. After that, the block stops looking at the input for a fixed number of clock cycles, so the ringing cannot reach the output. When that window closes, the block checks the input once more. If the input now differs from the output, that difference counts as a fresh edge right away, so a real transition that fell inside the window is never lost.

The raw input is asynchronous. It passes through a flop synchroniser before any decision is made. The output is a plain registered level. The block has no data stream, so there is no valid/ready handshake and no back-pressure. All pins are plain control pins. The block re-arms after every window without a reset, so it can follow a periodic waveform for as long as it runs.

Top module: `edge_lockout_deglitch`

## Requirements
- R1: A synchronous reset that is high for at least SYNC_STAGES+1 clock edges clears the blanking timer. It also loads `dout` from the synchronised input level, so no output edge follows the release of reset. An input change made right after reset is accepted with the normal latency of R2, even if reset arrived in the middle of a blanking window.
- R2: While the block is armed, an input change that is first captured at clock edge n appears on `dout` at edge n+SYNC_STAGES. With the defaults this is the third rising edge after the change.
- R3: Rising and falling input transitions go through the same detection path and give the same latency and blanking.
- R4: Once `dout` changes at edge E, it keeps its value at edges E+1 through E+BLANK_CYCLES, whatever the input does.
- R5: At edge E+BLANK_CYCLES+1 the synchronised input is compared with `dout`. If they differ, `dout` takes the input level and a new blanking window starts. If they match, `dout` stays put.
- R6: An input pulse only one clock wide is accepted as an edge when the block is armed. `dout` then returns to the idle level once the window ends, as R5 requires.
- R7: The block re-arms without reset after every window. A periodic input with ringing on each edge gives exactly one `dout` transition per real input transition.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous reset, active high |
| din_async | input | 1 | Raw, asynchronous input with ringing on its edges |
| dout | output | 1 | Registered clean level |

## Verification
The bench sends bursts of every length from a single edge up to one full window, in both polarities. Each burst settles either on the new level or back on the old one. A design that does not resample when the window ends would stay at the wrong level after an odd burst. A design with an off-by-one timer would move `dout` one edge early or late. The one-cycle pulse case catches a detector that waits for the input to settle. Reset is applied in the middle of a window to show that it clears the timer, and a long periodic run shows that the block keeps re-arming without losing or adding transitions.

// File: rtl/lockout_pkg.sv
package lockout_pkg;

  // Width needed to hold the blanking count itself (value BLANK_CYCLES).
  function automatic int unsigned cnt_bits(input int unsigned n);
    if (n < 1) return 1;
    return $clog2(n + 1);
  endfunction

endpackage

// File: rtl/lockout_sync.sv
module lockout_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic d_async,
  output logic q_sync
);

  logic [STAGES-1:0] chain;

  // The chain is never reset, so reset can load a valid level from it.
  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    if (i == 0) begin : g_first
      always_ff @(posedge clk) chain[0] <= d_async;
    end else begin : g_rest
      always_ff @(posedge clk) chain[i] <= chain[i-1];
    end
  end

  assign q_sync = chain[STAGES-1];

endmodule

// File: rtl/lockout_timer.sv
module lockout_timer #(
  parameter int unsigned BLANK_CYCLES = 20,
  parameter int unsigned CW           = 5
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  output logic [CW-1:0] cnt,
  output logic          armed
);

  localparam logic [CW-1:0] LOAD_VAL = CW'(BLANK_CYCLES);

  always_ff @(posedge clk) begin
    if (rst)             cnt <= '0;
    else if (load)       cnt <= LOAD_VAL;
    else if (cnt != '0)  cnt <= cnt - CW'(1);
  end

  assign armed = (cnt == '0);

endmodule

// File: rtl/lockout_hold.sv
module lockout_hold (
  input  logic clk,
  input  logic rst,
  input  logic lvl,
  input  logic armed,
  output logic take,
  output logic dout
);

  // The held level is the delayed copy; the XOR flags either edge polarity.
  // It also covers a change that happened during blanking.
  assign take = armed & (lvl ^ dout);

  always_ff @(posedge clk) begin
    if (rst)       dout <= lvl;
    else if (take) dout <= lvl;
  end

endmodule

// File: rtl/edge_lockout_deglitch.sv
module edge_lockout_deglitch #(
  parameter int unsigned SYNC_STAGES  = 2,
  parameter int unsigned BLANK_CYCLES = 20
) (
  input  logic clk,
  input  logic rst,
  input  logic din_async,
  output logic dout
);

  localparam int unsigned CW = lockout_pkg::cnt_bits(BLANK_CYCLES);

  logic          sync_lvl;
  logic          armed;
  logic          take;
  logic [CW-1:0] blank_cnt;

  lockout_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .d_async (din_async),
    .q_sync  (sync_lvl)
  );

  lockout_timer #(.BLANK_CYCLES(BLANK_CYCLES), .CW(CW)) u_timer (
    .clk   (clk),
    .rst   (rst),
    .load  (take),
    .cnt   (blank_cnt),
    .armed (armed)
  );

  lockout_hold u_hold (
    .clk   (clk),
    .rst   (rst),
    .lvl   (sync_lvl),
    .armed (armed),
    .take  (take),
    .dout  (dout)
  );

endmodule

// File: rtl/lockout_checker.sv
module lockout_checker #(
  parameter int unsigned BLANK_CYCLES = 20,
  parameter int unsigned CW           = 5
) (
  input logic          clk,
  input logic          rst,
  input logic          sync_lvl,
  input logic          dout,
  input logic [CW-1:0] cnt
);

  // R4: while the window is open the output does not move
  a_r4_hold_while_blank: assert property (@(posedge clk) disable iff (rst)
    (cnt != '0) |=> $stable(dout));

  // R4: the window counts down one step per cycle
  a_r4_count_down: assert property (@(posedge clk) disable iff (rst)
    (cnt != '0) |=> (cnt == $past(cnt) - CW'(1)));

  // R5: every output change opens a full window
  a_r5_change_opens_window: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && (dout != $past(dout))) |-> (cnt == CW'(BLANK_CYCLES)));

  // R2: when armed, a mismatch is taken on the next edge
  a_r2_armed_accepts: assert property (@(posedge clk) disable iff (rst)
    ((cnt == '0) && (sync_lvl != dout)) |=> (dout == $past(sync_lvl)));

  // R1: the counter never exceeds its load value
  a_r1_count_bounded: assert property (@(posedge clk) disable iff (rst)
    (cnt <= CW'(BLANK_CYCLES)));

endmodule

bind edge_lockout_deglitch lockout_checker #(
  .BLANK_CYCLES(BLANK_CYCLES),
  .CW          (CW)
) u_lockout_checker (
  .clk      (clk),
  .rst      (rst),
  .sync_lvl (sync_lvl),
  .dout     (dout),
  .cnt      (blank_cnt)
);

// File: tb/test_edge_lockout_deglitch.sv
module test_edge_lockout_deglitch;

  localparam int B = 5;
  localparam int S = 2;
  localparam int LAT = S + 1;   // edges from change to dout

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic din = 1'b0;
  logic dout;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  int  transitions = 0;
  bit  counting = 1'b0;
  logic prev_dout = 1'b0;

  always #2 clk = ~clk;   // 250 MHz

  edge_lockout_deglitch #(.SYNC_STAGES(S), .BLANK_CYCLES(B)) i_edge_lockout_deglitch (
    .clk       (clk),
    .rst       (rst),
    .din_async (din),
    .dout      (dout)
  );

  always @(negedge clk) begin
    if (counting && dout != prev_dout) transitions++;
    prev_dout <= dout;
  end

  task automatic chk(input logic got, input logic exp, input string req);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s at %0t: got %b expected %b", req, $time, got, exp);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  // The first edge flips to ~start, then `extra` more one-cycle toggles follow.
  task automatic burst(input logic start, input int extra);
    logic fin;
    logic exp;
    string tag;
    fin = (extra % 2 == 0) ? ~start : start;
    @(negedge clk) din = ~start;
    for (int k = 1; k <= B + LAT + 4; k++) begin
      @(negedge clk);
      if (k < LAT)            begin exp = start;  tag = "R2 before latency"; end
      else if (k == LAT)      begin exp = ~start; tag = (extra == 1) ? "R6 narrow pulse" : (start ? "R3 falling edge" : "R2 rising edge"); end
      else if (k <= LAT + B)  begin exp = ~start; tag = "R4 blanking hold"; end
      else                    begin exp = fin;    tag = "R5 expiry resample"; end
      chk(dout, exp, tag);
      if (k <= extra) din = ~din;
    end
    repeat (B + 4) @(negedge clk);
    chk(dout, fin, "R5 settled level");
  endtask

  initial begin
    #(4 * 20000);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    logic lvl;
    // R1: reset with input high loads the level, no edge afterwards
    din = 1'b1;
    rst = 1'b1;
    repeat (5) @(negedge clk);
    chk(dout, 1'b1, "R1 reset loads level");
    rst = 1'b0;
    for (int k = 0; k < B + 4; k++) begin
      @(negedge clk);
      chk(dout, 1'b1, "R1 no spurious edge");
    end

    // R1: reset in the middle of a window clears the timer
    din = 1'b0;
    repeat (LAT) @(negedge clk);
    chk(dout, 1'b0, "R1 pre-reset accept");
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    din = 1'b1;
    repeat (LAT) @(negedge clk);
    chk(dout, 1'b1, "R1 accept right after reset");
    repeat (B + 4) @(negedge clk);

    // R2..R6: sweep of burst lengths in both polarities
    lvl = dout;
    for (int e = 0; e <= B; e++) begin
      for (int p = 0; p < 2; p++) begin
        burst(lvl, e);
        lvl = dout;
      end
    end

    // R7: periodic waveform with two ringing toggles on every edge
    counting = 1'b1;
    for (int h = 0; h < 40; h++) begin
      @(negedge clk) din = ~din;
      @(negedge clk) din = ~din;
      @(negedge clk) din = ~din;
      repeat (B + 4) @(negedge clk);
    end
    repeat (4) @(negedge clk);
    counting = 1'b0;
    checks++;
    if (transitions != 40) begin
      errors++;
      $display("FAIL R7 transition count: got %0d expected %0d", transitions, 40);
    end
    chk(dout, din, "R7 final level");

    finish_run();
  end

endmodule